// File: doc/BRIEF.md
# Reversible 16-bit Processor Core

A multi-cycle processor core for a 16-bit instruction set in which every instruction undoes itself when executed a second time. Arithmetic, logic and compare results are never written over the destination. They are XOR-folded into it. The only control transfer is a conditional jump that exchanges the program counter with a register. The only memory access exchanges a register with a 16-bit word in memory. Execution begins at address 0x0000 after reset and continues until a halt instruction or a fault.

The core holds sixteen 16-bit registers, a program counter and an instruction register. A five-phase state machine drives them: fetch, execute, jump-target read, swap load and swap store. All memory traffic goes through a single byte-addressed port that carries 16-bit words, with a request held until the memory raises ready. The `halted` output rises when execution stops, and `fault` tells a fault stop apart from a normal halt.

Top module: `rev16_core`

## Requirements
- R1: While reset is high and after it is released, `halted` and `fault` are low and all registers are zero. In the first cycle after release, the core issues a read request to byte address 0x0000.
- R2: Add, subtract, multiply and unsigned divide XOR the low 16 bits of (second op third) into the first register. A zero divisor contributes 0.
- R3: Rotate right, rotate left, logical shift right and shift left take their count from bits 3:0 of the third register. Shifts fill with zeros. The result is XOR-folded into the first register.
- R4: AND and OR of the second and third registers are XOR-folded into the first register.
- R5: Compare treats the second and third registers as two's-complement values. It XORs 0xFFFF (less), 0x0000 (equal) or 0x0001 (greater) into the first register.
- R6: Xor-immediate XORs the first register with bits 7:0 of the instruction, sign-extended to 16 bits.
- R7: Register swap exchanges the first and second registers.
- R8: Memory swap reads the word at the address held in the second register. It then writes the old first register to that same address and loads the read value into the first register. Words are little-endian: the byte at A sits in bits 7:0 and the byte at A+1 (mod 0x10000) in bits 15:8. A request keeps its address and direction until ready.
- R9: The jump compares the second and third registers. If they differ, the next fetch is at PC+2. If they are equal, the first register receives the jump's own address and the next fetch is at target+2. The PC wraps from 0xFFFE to 0x0000.
- R10: A taken jump whose target is odd, or whose target word differs from the jump instruction, sets `fault` and halts.
- R11: An instruction whose first register also appears as one of its source registers sets `fault` and halts without writing any register or memory. Sources are the second and third registers for arithmetic, compare and jump, and the second register for both swaps.
- R12: The halt instruction raises `halted` with `fault` low. Once halted, the core issues no further requests, and `halted` and `fault` hold until reset.
- R13: Instruction fields are: opcode in bits 15:12, first register in 11:8, second in 7:4, third in 3:0, and the immediate in 7:0. Opcodes are 0 add, 1 sub, 2 rotate right, 3 rotate left, 4 shift right, 5 shift left, 6 and, 7 or, 8 mul, 9 div, A compare, B jump, C xor-immediate, D register swap, E memory swap, F halt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Byte address of the 16-bit access |
| mem_wdata | output | 16 | Little-endian write word |
| mem_rdata | input | 16 | Little-endian read word, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the pending request |
| halted | output | 1 | Execution has stopped |
| fault | output | 1 | The stop was caused by a fault |

## Verification
Register results only become visible when a later memory swap stores them. Each program therefore ends by swapping the result into a data word, and the bench reads that word only after `halted` rises, when no request can follow. The first-fetch check is sampled on the falling edge one rising edge after reset is released, because the fetch request comes straight from the reset state. Ordering is checked at the memory itself. The responder answers each request one edge after it appears, records every completed transaction, and flags any write that does not follow a read of the same address. After each halt, ten further cycles are watched for stray requests.

// File: rtl/rev16_pkg.sv
package rev16_pkg;

    localparam int XLEN   = 16;
    localparam int NREG   = 16;
    localparam int RIDX   = $clog2(NREG);
    localparam int SHW    = $clog2(XLEN);
    localparam int IMMW   = 8;
    localparam int STEP_B = XLEN / 8;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [RIDX-1:0] ridx_t;

    typedef enum logic [3:0] {
        OP_ADD    = 4'h0,
        OP_SUB    = 4'h1,
        OP_RORT   = 4'h2,
        OP_ROLT   = 4'h3,
        OP_SHRL   = 4'h4,
        OP_SHLL   = 4'h5,
        OP_AND    = 4'h6,
        OP_OR     = 4'h7,
        OP_MUL    = 4'h8,
        OP_DIV    = 4'h9,
        OP_CMP    = 4'hA,
        OP_JSWAP  = 4'hB,
        OP_XORIMM = 4'hC,
        OP_SWAPRR = 4'hD,
        OP_SWAPRM = 4'hE,
        OP_HALT   = 4'hF
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_EXEC,
        ST_JREAD,
        ST_LOAD,
        ST_STORE,
        ST_STOP
    } state_e;

    typedef struct packed {
        opcode_e         op;
        ridx_t           rd;
        ridx_t           rs;
        ridx_t           rt;
        logic [IMMW-1:0] imm;
    } fields_t;

    function automatic fields_t split_insn(word_t w);
        fields_t f;
        f.op  = opcode_e'(w[15:12]);
        f.rd  = w[11:8];
        f.rs  = w[7:4];
        f.rt  = w[3:0];
        f.imm = w[IMMW-1:0];
        return f;
    endfunction

    // true for every opcode whose result is xor-folded into the first register
    function automatic logic is_fold(opcode_e op);
        return (op <= OP_CMP) || (op == OP_XORIMM);
    endfunction

    function automatic word_t rot_right(word_t a, logic [SHW-1:0] n);
        return (a >> n) | (a << (XLEN - int'(n)));
    endfunction

    function automatic word_t rot_left(word_t a, logic [SHW-1:0] n);
        return (a << n) | (a >> (XLEN - int'(n)));
    endfunction

    function automatic word_t sign_cmp(word_t a, word_t b);
        if ($signed(a) < $signed(b))      return '1;
        else if ($signed(a) > $signed(b)) return word_t'(1);
        else                              return '0;
    endfunction

endpackage

// File: rtl/rev16_decode.sv
module rev16_decode
    import rev16_pkg::*;
(
    input  word_t   insn,
    output fields_t fields,
    output logic    clash
);

    fields_t f;

    always_comb begin
        f = split_insn(insn);
        unique case (f.op)
            OP_SWAPRR, OP_SWAPRM: clash = (f.rd == f.rs);
            OP_XORIMM, OP_HALT:   clash = 1'b0;
            default:              clash = (f.rd == f.rs) || (f.rd == f.rt);
        endcase
    end

    assign fields = f;

endmodule

// File: rtl/rev16_alu.sv
module rev16_alu
    import rev16_pkg::*;
(
    input  opcode_e         op,
    input  word_t           a,
    input  word_t           b,
    input  logic [IMMW-1:0] imm,
    output word_t           fold
);

    logic [SHW-1:0] amt;
    word_t          quot;

    assign amt  = b[SHW-1:0];
    assign quot = (b == '0) ? '0 : (a / b);

    always_comb begin
        unique case (op)
            OP_ADD:    fold = a + b;
            OP_SUB:    fold = a - b;
            OP_RORT:   fold = rot_right(a, amt);
            OP_ROLT:   fold = rot_left(a, amt);
            OP_SHRL:   fold = a >> amt;
            OP_SHLL:   fold = a << amt;
            OP_AND:    fold = a & b;
            OP_OR:     fold = a | b;
            OP_MUL:    fold = a * b;
            OP_DIV:    fold = quot;
            OP_CMP:    fold = sign_cmp(a, b);
            OP_XORIMM: fold = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
            default:   fold = '0;
        endcase
    end

endmodule

// File: rtl/rev16_regfile.sv
module rev16_regfile #(
    parameter int  N  = 16,
    parameter int  W  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] ra0,
    input  logic [IW-1:0] ra1,
    input  logic [IW-1:0] ra2,
    output logic [W-1:0]  rd0,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we0,
    input  logic [IW-1:0] wa0,
    input  logic [W-1:0]  wd0,
    input  logic          we1,
    input  logic [IW-1:0] wa1,
    input  logic [W-1:0]  wd1
);

    logic [W-1:0] q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) q[i] <= '0;
        end else begin
            if (we1) q[wa1] <= wd1;
            if (we0) q[wa0] <= wd0;
        end
    end

    assign rd0 = q[ra0];
    assign rd1 = q[ra1];
    assign rd2 = q[ra2];

endmodule

// File: rtl/rev16_core.sv
module rev16_core
    import rev16_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input  logic        clk,
    input  logic        rst,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    input  logic        mem_ready,
    output logic        halted,
    output logic        fault
);

    localparam word_t STEP = word_t'(STEP_B);

    state_e  state_q;
    word_t   pc_q, ir_q, hold_q;
    logic    fault_q;

    fields_t f;
    logic    clash;
    word_t   v_d, v_s, v_t, fold;
    word_t   pc_inc;
    logic    ops_equal, tgt_match;

    logic    we0, we1;
    ridx_t   wa0, wa1;
    word_t   wd0, wd1;

    rev16_decode u_dec (
        .insn   (ir_q),
        .fields (f),
        .clash  (clash)
    );

    rev16_regfile #(.N(NREG), .W(XLEN)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra0 (f.rd),
        .ra1 (f.rs),
        .ra2 (f.rt),
        .rd0 (v_d),
        .rd1 (v_s),
        .rd2 (v_t),
        .we0 (we0),
        .wa0 (wa0),
        .wd0 (wd0),
        .we1 (we1),
        .wa1 (wa1),
        .wd1 (wd1)
    );

    rev16_alu u_alu (
        .op   (f.op),
        .a    (v_s),
        .b    (v_t),
        .imm  (f.imm),
        .fold (fold)
    );

    assign pc_inc    = pc_q + STEP;
    assign ops_equal = (v_s == v_t);
    assign tgt_match = (mem_rdata == ir_q);

    // memory request generation
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = pc_q;
        mem_wdata = v_d;
        unique case (state_q)
            ST_FETCH: mem_req = 1'b1;
            ST_JREAD: begin
                mem_req  = 1'b1;
                mem_addr = v_d;
            end
            ST_LOAD: begin
                mem_req  = 1'b1;
                mem_addr = v_s;
            end
            ST_STORE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = v_s;
            end
            default: ;
        endcase
    end

    // register write ports
    always_comb begin
        we0 = 1'b0;
        wa0 = f.rd;
        wd0 = v_d ^ fold;
        we1 = 1'b0;
        wa1 = f.rs;
        wd1 = v_d;
        unique case (state_q)
            ST_EXEC: begin
                if (!clash) begin
                    if (is_fold(f.op)) begin
                        we0 = 1'b1;
                    end else if (f.op == OP_SWAPRR) begin
                        we0 = 1'b1;
                        wd0 = v_s;
                        we1 = 1'b1;
                    end
                end
            end
            ST_JREAD: begin
                if (mem_ready && tgt_match) begin
                    we0 = 1'b1;
                    wd0 = pc_q;
                end
            end
            ST_STORE: begin
                if (mem_ready) begin
                    we0 = 1'b1;
                    wd0 = hold_q;
                end
            end
            default: ;
        endcase
    end

    // sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            pc_q    <= RESET_PC;
            ir_q    <= '0;
            hold_q  <= '0;
            fault_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_FETCH: begin
                    if (mem_ready) begin
                        ir_q    <= mem_rdata;
                        state_q <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    if (clash) begin
                        fault_q <= 1'b1;
                        state_q <= ST_STOP;
                    end else begin
                        unique case (f.op)
                            OP_JSWAP: begin
                                if (!ops_equal) begin
                                    pc_q    <= pc_inc;
                                    state_q <= ST_FETCH;
                                end else if (v_d[0]) begin
                                    fault_q <= 1'b1;
                                    state_q <= ST_STOP;
                                end else begin
                                    state_q <= ST_JREAD;
                                end
                            end
                            OP_SWAPRM: state_q <= ST_LOAD;
                            OP_HALT:   state_q <= ST_STOP;
                            default: begin
                                pc_q    <= pc_inc;
                                state_q <= ST_FETCH;
                            end
                        endcase
                    end
                end
                ST_JREAD: begin
                    if (mem_ready) begin
                        if (tgt_match) begin
                            pc_q    <= v_d + STEP;
                            state_q <= ST_FETCH;
                        end else begin
                            fault_q <= 1'b1;
                            state_q <= ST_STOP;
                        end
                    end
                end
                ST_LOAD: begin
                    if (mem_ready) begin
                        hold_q  <= mem_rdata;
                        state_q <= ST_STORE;
                    end
                end
                ST_STORE: begin
                    if (mem_ready) begin
                        pc_q    <= pc_inc;
                        state_q <= ST_FETCH;
                    end
                end
                default: state_q <= ST_STOP;
            endcase
        end
    end

    assign halted = (state_q == ST_STOP);
    assign fault  = fault_q;

endmodule

// File: rtl/rev16_core_chk.sv
module rev16_core_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ready,
    input logic [15:0] mem_addr,
    input logic        halted,
    input logic        fault,
    input logic        in_fetch,
    input logic [15:0] fetch_pc
);

    assert_first_fetch_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mem_req && !mem_we && mem_addr == 16'h0000));

    assert_req_held_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_fetch_even_R9: assert property (@(posedge clk) disable iff (rst)
        in_fetch |-> !fetch_pc[0]);

    assert_fault_stops_R10: assert property (@(posedge clk) disable iff (rst)
        fault |-> halted);

    assert_stop_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !mem_req && $stable(fault)));

endmodule

bind rev16_core rev16_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .halted    (halted),
    .fault     (fault),
    .in_fetch  (state_q == ST_FETCH),
    .fetch_pc  (pc_q)
);

// File: tb/rev16_core_tb.sv
module rev16_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_req, mem_we, mem_ready;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        halted, fault;

    always #10 clk = ~clk;

    rev16_core u_dut (
        .clk       (clk),
        .rst       (rst),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .halted    (halted),
        .fault     (fault)
    );

    logic [7:0] mem [logic [15:0]];
    int n_cmp = 0;
    int n_bad = 0;
    int post_req = 0;
    int order_bad = 0;
    int cyc = 0;
    logic        last_rd_ok = 1'b0;
    logic [15:0] last_rd = '0;

    function automatic logic [7:0] rdb(logic [15:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    function automatic logic [15:0] rdw(logic [15:0] a);
        logic [15:0] a1;
        a1 = a + 16'd1;
        return {rdb(a1), rdb(a)};
    endfunction

    task automatic put_w(logic [15:0] a, logic [15:0] w);
        logic [15:0] a1;
        a1 = a + 16'd1;
        mem[a]  = w[7:0];
        mem[a1] = w[15:8];
    endtask

    // responder: one edge of latency, little-endian with address wrap
    always @(posedge clk) begin
        if (rst) begin
            mem_ready <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ready) begin
            mem_ready <= 1'b1;
            mem_rdata <= rdw(mem_addr);
        end else if (mem_req && mem_ready) begin
            if (mem_we) begin
                if (!(last_rd_ok && last_rd == mem_addr)) order_bad++;
                put_w(mem_addr, mem_wdata);
                last_rd_ok = 1'b0;
            end else begin
                last_rd_ok = 1'b1;
                last_rd    = mem_addr;
            end
            mem_ready <= 1'b0;
        end else begin
            mem_ready <= 1'b0;
        end
    end

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            report();
            $finish;
        end
    end

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_prog(bit chk_reset);
        @(negedge clk);
        rst = 1'b1;
        order_bad = 0;
        repeat (3) @(negedge clk);
        if (chk_reset) begin
            check("R1 halted during reset", 16'(halted), 16'd0);
            check("R1 fault during reset", 16'(fault), 16'd0);
        end
        rst = 1'b0;
        @(negedge clk);
        if (chk_reset) begin
            check("R1 first request read", {14'd0, mem_req, mem_we}, 16'b10);
            check("R1 first request addr", mem_addr, 16'h0000);
        end
        for (int i = 0; i < 4000 && !halted; i++) @(negedge clk);
        check("R12 program reached halt", 16'(halted), 16'd1);
        post_req = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (mem_req) post_req++;
        end
        check("R12 no request after halt", 16'(post_req), 16'd0);
        check("R8 write follows read of same address", 16'(order_bad), 16'd0);
    endtask

    function automatic string tag_of(logic [3:0] op, logic flt);
        if (flt) return "R11";
        case (op)
            4'h0, 4'h1, 4'h8, 4'h9: return "R2";
            4'h2, 4'h3, 4'h4, 4'h5: return "R3";
            4'h6, 4'h7:             return "R4";
            4'hA:                   return "R5";
            4'hB:                   return "R9";
            4'hC:                   return "R6";
            4'hD:                   return "R7";
            default:                return "R8";
        endcase
    endfunction

    // {instruction, first reg, second reg, third reg, expected word, fault}
    localparam int NV = 22;
    localparam logic [95:0] VEC [NV] = '{
        {16'h0123, 16'h1111, 16'h7000, 16'h9234, 16'h1325, 16'd0},
        {16'h1123, 16'h0000, 16'h0003, 16'h0005, 16'hFFFE, 16'd0},
        {16'h2123, 16'h0000, 16'h0001, 16'h0011, 16'h8000, 16'd0},
        {16'h3123, 16'h00FF, 16'h8001, 16'h0004, 16'h00E7, 16'd0},
        {16'h4123, 16'h0000, 16'h8000, 16'h000F, 16'h0001, 16'd0},
        {16'h5123, 16'h0F0F, 16'h00F0, 16'h0024, 16'h000F, 16'd0},
        {16'h6123, 16'h1234, 16'hF0F0, 16'hFF00, 16'hE234, 16'd0},
        {16'h7123, 16'h0000, 16'h00F0, 16'h0F00, 16'h0FF0, 16'd0},
        {16'h8123, 16'h0000, 16'h0100, 16'h0101, 16'h0100, 16'd0},
        {16'h9123, 16'h0001, 16'h0064, 16'h0007, 16'h000F, 16'd0},
        {16'h9123, 16'h5555, 16'h1234, 16'h0000, 16'h5555, 16'd0},
        {16'hA123, 16'h0000, 16'h8000, 16'h0001, 16'hFFFF, 16'd0},
        {16'hA123, 16'h0003, 16'h0009, 16'h0005, 16'h0002, 16'd0},
        {16'hA123, 16'h00AA, 16'h7777, 16'h7777, 16'h00AA, 16'd0},
        {16'hC1F0, 16'h1234, 16'h0000, 16'h0000, 16'hEDC4, 16'd0},
        {16'hC17F, 16'h0000, 16'h0000, 16'h0000, 16'h007F, 16'd0},
        {16'hD120, 16'h1111, 16'hBEEF, 16'h0000, 16'hBEEF, 16'd0},
        {16'hE120, 16'hABCD, 16'hFFFF, 16'h0000, 16'h4000, 16'd0},
        {16'hB123, 16'h0022, 16'h0001, 16'h0002, 16'h0022, 16'd0},
        {16'h0121, 16'h1111, 16'h0001, 16'h0002, 16'h0000, 16'd1},
        {16'hD110, 16'h1111, 16'h0001, 16'h0002, 16'h0000, 16'd1},
        {16'hB121, 16'h0040, 16'h0001, 16'h0002, 16'h0000, 16'd1}
    };

    initial begin
        // vector table: load three registers, run one instruction, store the first
        for (int v = 0; v < NV; v++) begin
            logic [15:0] ins, cv, av, bv, ev;
            logic        flt;
            string       t;
            ins = VEC[v][95:80];
            cv  = VEC[v][79:64];
            av  = VEC[v][63:48];
            bv  = VEC[v][47:32];
            ev  = VEC[v][31:16];
            flt = VEC[v][0];
            t   = $sformatf("%s/R13 vector %0d", tag_of(ins[15:12], flt), v);
            mem.delete();
            put_w(16'h0000, 16'hC840);
            put_w(16'h0002, 16'hC942);
            put_w(16'h0004, 16'hCA44);
            put_w(16'h0006, 16'hE180);
            put_w(16'h0008, 16'hE290);
            put_w(16'h000A, 16'hE3A0);
            put_w(16'h000C, ins);
            put_w(16'h000E, 16'hE180);
            put_w(16'h0010, 16'hF000);
            put_w(16'h0040, cv);
            put_w(16'h0042, av);
            put_w(16'h0044, bv);
            run_prog(v == 0);
            check({t, " fault"}, 16'(fault), 16'(flt));
            check({t, " result word"}, rdw(16'h0040), ev);
            if (ins[15:12] == 4'hE) begin
                check("R8 wrapped write high byte at 0x0000", 16'(rdb(16'h0000)), 16'(cv[15:8]));
                check("R8 write low byte at 0xFFFF", 16'(rdb(16'hFFFF)), 16'(cv[7:0]));
            end
        end

        // taken jumps, resume at target+2, PC wrap from 0xFFFE
        mem.delete();
        put_w(16'h0000, 16'hC201);
        put_w(16'h0002, 16'hB320);
        put_w(16'h0004, 16'hC1FC);
        put_w(16'h0006, 16'hB100);
        put_w(16'hFFFC, 16'hB100);
        put_w(16'hFFFE, 16'hC310);
        put_w(16'h0010, 16'hB320);
        put_w(16'h0012, 16'hE340);
        put_w(16'h0014, 16'hC520);
        put_w(16'h0016, 16'hE150);
        put_w(16'h0018, 16'hF000);
        run_prog(1'b0);
        check("R9 jump program fault", 16'(fault), 16'd0);
        check("R9 wrap and second jump link", rdw(16'h0000), 16'h0002);
        check("R9 first jump link", rdw(16'h0020), 16'h0006);

        // odd target
        mem.delete();
        put_w(16'h0000, 16'hC103);
        put_w(16'h0002, 16'hB100);
        run_prog(1'b0);
        check("R10 odd target fault", 16'(fault), 16'd1);

        // mismatching target word
        mem.delete();
        put_w(16'h0000, 16'hC110);
        put_w(16'h0002, 16'hB100);
        put_w(16'h0010, 16'hF000);
        run_prog(1'b0);
        check("R10 mismatched target fault", 16'(fault), 16'd1);

        // matching target, then halt right after it
        mem.delete();
        put_w(16'h0000, 16'hC110);
        put_w(16'h0002, 16'hB100);
        put_w(16'h0010, 16'hB100);
        put_w(16'h0012, 16'hF000);
        put_w(16'h0014, 16'hC203);
        run_prog(1'b0);
        check("R12 halt without fault", 16'(fault), 16'd0);
        check("R12 halted holds", 16'(halted), 16'd1);

        report();
        $finish;
    end

endmodule